// File: doc/BRIEF.md
# Tone Event Interrupt FIFO

This block gathers tone-disable events from a bank of echo canceller channels and hands them to a host processor as a queue of channel numbers. Each channel drives one status level. A rising edge on that level is one event and a falling edge is another. Every event is latched as pending for its channel. A round-robin scanner moves pending events into a FIFO, one per clock.

The host sees an interrupt line that stays high while the FIFO holds at least one entry. It services the interrupt by pulsing a read strobe. Each strobe returns the oldest channel number and removes it from the FIFO. A read of an empty FIFO returns a reserved code. A sticky flag records any event that was lost because the FIFO was full.

Top module: `tone_irq_fifo`

## Requirements
- R1: While rst_n is low, irq is high-impedance. After reset the FIFO is empty, ovf is 0, irq is 0 and rd_data holds the reserved code (all ones, 63 with the default parameters).
- R2: A 0-to-1 change on tone_status[c] queues one entry for channel c. irq is high after the second rising clock edge that follows the change.
- R3: A 1-to-0 change on tone_status[c] queues its own separate entry for channel c, in the same way as R2.
- R4: When rd_stb is sampled high on a rising edge and the FIFO is not empty, rd_data takes {1'b0, channel} of the oldest entry on that edge and the entry is removed. Entries are returned in the order they were queued. rd_data changes on no other edge.
- R5: irq stays high while the FIFO holds any entry. It goes low on the edge of the read that removes the last entry.
- R6: Events that occur together are all queued, one per clock. The scan starts at the channel after the last one served, wraps from NCH-1 to 0, and starts at channel 0 after reset.
- R7: A read of an empty FIFO sets rd_data to the reserved all-ones code and changes nothing else.
- R8: An event reaching a full FIFO with no read on the same edge is dropped and sets ovf. ovf stays set until reset, and the stored entries are unchanged.
- R9: When an event reaches a full FIFO on the same edge as a read, both take effect: the oldest entry leaves, the new entry is stored, and ovf is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_status | input | NCH | Tone-disable status level per channel |
| rd_stb | input | 1 | Host read strobe, one entry per high cycle |
| rd_data | output | CW+1 | Channel read out, zero-extended, or the all-ones empty code |
| irq | output | 1 | Entries pending; high-impedance during reset |
| ovf | output | 1 | Sticky flag for a lost event |

## Verification
Single onsets and releases on one channel establish the two-edge latency and show that both directions of change produce an entry. A burst of several channels changing together, with the scan pointer away from zero, tells round-robin order apart from fixed priority. A wrap past the top channel is also part of that burst. Filling the FIFO, then making an event land on the same edge as a read, separates the R9 case from the dropped event of R8. The drain that follows proves the stored order survived both. A final read of the empty FIFO exercises the reserved code.

// File: rtl/tone_irq_pkg.sv
package tone_irq_pkg;
  parameter int unsigned DEF_NCH   = 32;
  parameter int unsigned DEF_DEPTH = 16;

  // width of an index into n items, never below one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tone_evt_pending.sv
module tone_evt_pending #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] status,
  input  logic [NCH-1:0] grant,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] seen_q;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_d;
  logic [NCH-1:0] chg;

  // any level change, rising or falling, is an event
  assign chg = status ^ seen_q;

  always_comb begin
    // a fresh change wins over the clear of a served flag
    pend_d = (pend_q & ~grant) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      pend_q <= '0;
    end else begin
      seen_q <= status;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/tone_rr_pick.sv
module tone_rr_pick #(
  parameter int unsigned NCH = 32,
  parameter int unsigned CW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  output logic           valid,
  output logic [CW-1:0]  idx,
  output logic [NCH-1:0] grant
);
  logic [CW-1:0] ptr_q;
  logic [CW-1:0] ptr_d;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int unsigned k = 0; k < NCH; k++) begin
      int unsigned j;
      j = int'(ptr_q) + k;
      if (j >= NCH) j = j - NCH;
      if (!valid && pend[j]) begin
        valid = 1'b1;
        idx   = CW'(j);
      end
    end
  end

  always_comb begin
    grant = '0;
    ptr_d = ptr_q;
    if (valid) begin
      grant[idx] = 1'b1;
      ptr_d      = (idx == CW'(NCH-1)) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tone_chan_fifo.sv
module tone_chan_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = tone_irq_pkg::idx_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          wr_en, rd_en;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign rd_en = pop && !empty;
  assign wr_en = push && (!full || rd_en);
  assign rdata = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_en) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (rd_en) rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tone_irq_fifo.sv
module tone_irq_fifo #(
  parameter int unsigned NCH   = tone_irq_pkg::DEF_NCH,
  parameter int unsigned DEPTH = tone_irq_pkg::DEF_DEPTH,
  localparam int unsigned CW   = tone_irq_pkg::idx_w(NCH),
  localparam int unsigned DW   = CW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tone_status,
  input  logic           rd_stb,
  output logic [DW-1:0]  rd_data,
  output logic           irq,
  output logic           ovf
);
  localparam logic [DW-1:0] NO_ENTRY = '1;

  logic [NCH-1:0] pend, grant_oh;
  logic           evt_valid;
  logic [CW-1:0]  evt_ch;
  logic [CW-1:0]  head;
  logic           empty, full, pop, push_ok, drop;
  logic [DW-1:0]  rd_q, rd_d;
  logic           ovf_q, ovf_d;

  tone_evt_pending #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .status(tone_status),
    .grant(grant_oh), .pend(pend)
  );

  tone_rr_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend),
    .valid(evt_valid), .idx(evt_ch), .grant(grant_oh)
  );

  assign pop     = rd_stb && !empty;
  assign push_ok = evt_valid && (!full || pop);
  assign drop    = evt_valid && full && !pop;

  tone_chan_fifo #(.DEPTH(DEPTH), .W(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(evt_valid), .wdata(evt_ch),
    .pop(rd_stb), .rdata(head), .empty(empty), .full(full)
  );

  always_comb begin
    rd_d  = rd_q;
    if (rd_stb) rd_d = empty ? NO_ENTRY : {1'b0, head};
    ovf_d = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= NO_ENTRY;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      ovf_q <= ovf_d;
    end
  end

  assign rd_data = rd_q;
  assign ovf     = ovf_q;
  assign irq     = rst_n ? !empty : 1'bz;
endmodule

// File: rtl/tone_irq_fifo_chk.sv
module tone_irq_fifo_chk #(
  parameter int unsigned NCH = 32,
  parameter int unsigned DW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_stb,
  input logic [DW-1:0]  rd_data,
  input logic           irq,
  input logic           ovf,
  input logic [NCH-1:0] grant,
  input logic           push
);
  // R2
  push_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> irq);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_stb) |=> irq);

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && rd_stb) |=> (rd_data == '1));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R8
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> irq);
endmodule

bind tone_irq_fifo tone_irq_fifo_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
  .irq(irq), .ovf(ovf), .grant(grant_oh), .push(push_ok)
);

// File: tb/tb_tone_irq_fifo.sv
module tb_tone_irq_fifo;
  localparam int NCH   = 32;
  localparam int DEPTH = 16;
  localparam int DW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] tone_status = '0;
  logic          rd_stb = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq, ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rr_ptr = 0;
  logic rd_seen = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #5 clk = ~clk;

  tone_irq_fifo #(.NCH(NCH), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tone_status(tone_status),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver: queue expected entries for a set of changed channels in scan order (R6)
  task automatic queue_events(input logic [NCH-1:0] mask);
    int start;
    start = rr_ptr;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = (start + k) % NCH;
      if (mask[j]) begin
        exp_q.push_back(DW'(j));
        rr_ptr = (j + 1) % NCH;
      end
    end
  endtask

  task automatic toggle(input logic [NCH-1:0] mask);
    @(negedge clk);
    tone_status = tone_status ^ mask;
    queue_events(mask);
  endtask

  task automatic host_read();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // monitor: compare each read result against the scoreboard
  always @(posedge clk) rd_seen <= rd_stb;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R7 empty read", rd_data, {DW{1'b1}});
      else                   chk("R4 read order", rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq high-z in reset", {31'd0, irq === 1'bz}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 ovf after reset", ovf, 0);
    chk("R1 rd_data after reset", rd_data, 63);

    // R2: single onset, latency of two edges
    toggle(32'h1 << 5);
    @(negedge clk);
    chk("R2 irq not yet", irq, 0);
    @(negedge clk);
    chk("R2 irq raised", irq, 1);
    host_read();
    @(negedge clk);
    chk("R5 irq low after last read", irq, 0);

    // R3: release of the same channel gives its own entry
    toggle(32'h1 << 5);
    repeat (3) @(negedge clk);
    chk("R3 irq on release", irq, 1);
    host_read();
    @(negedge clk);
    chk("R3 irq cleared", irq, 0);

    // R6: burst, scan resumes at 6, wraps past 31
    toggle((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20) | (32'h1 << 31));
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      host_read();
      chk("R5 irq held while entries remain", irq, 1);
    end
    host_read();
    @(negedge clk);
    chk("R5 irq low after drain", irq, 0);

    // R7: empty read
    host_read();
    chk("R7 ovf unchanged", ovf, 0);

    // fill: channels 0..15 toggled together, scan starts at 4
    toggle(32'h0000_FFFF);
    repeat (22) @(negedge clk);
    chk("R6 full irq", irq, 1);

    // R9: event on ch 20 meets a read on the same edge while full
    @(negedge clk);
    tone_status[20] = ~tone_status[20];
    exp_q.push_back(DW'(20));
    rr_ptr = 21;
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
    chk("R9 no overflow on push with read", ovf, 0);

    // R8: event on ch 21 while full is dropped
    @(negedge clk);
    tone_status[21] = 1'b1;
    rr_ptr = 22;
    repeat (4) @(negedge clk);
    chk("R8 overflow set", ovf, 1);
    for (int i = 0; i < DEPTH; i++) host_read();
    @(negedge clk);
    chk("R8 drained, irq low", irq, 0);
    chk("R8 overflow sticky", ovf, 1);
    host_read();
    chk("R7 empty after drain", {31'd0, irq}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule